// File: doc/BRIEF.md
# Temperature Limit Alarm Block

This block holds the most recent die temperature reading and four limits that the host can program. It compares every accepted reading against all four limits in parallel, and it keeps a sticky alarm bit for each limit. Readings arrive on a one-cycle strobe as 11-bit signed values with 0.25 °C per LSB, which gives a range of -256.00 to +255.75 °C. A byte-wide register port connects the block to a host bus front end. Reads from that port are combinational from the address, and writes take effect at the clock edge.

Every temperature-format value sits in a 16-bit register pair as bits [12:2]. The low byte is at the lower address. The host clears alarms by writing a one-hot mask to a clear register. Writing a one to the disable bit in the configuration register freezes the block: it then ignores readings and raises no alarms.

Top module: `thermal_limit_monitor`

## Requirements
- R1: When a strobe arrives with the sensor enabled, the reading is stored in the temperature pair at 0x31 (low byte) and 0x32 (high byte), and it can be read there from the next cycle. The value occupies pair bits [12:2].
- R2: There are four limit pairs, each written and read one byte at a time: high at 0x1C/0x1D, low at 0x1E/0x1F, critical-high at 0x20/0x21, critical-low at 0x22/0x23. Each pair holds its value in bits [12:2].
- R3: Bits [1:0] and [15:13] of every temperature-format pair always read as zero, and writes to those bits are discarded.
- R4: The status register is at 0x33, bits [3:0]. Bit0 (high) and bit2 (critical-high) set when an accepted reading is strictly greater than their limit. Bit1 (low) and bit3 (critical-low) set when it is strictly less than their limit. All comparisons are signed.
- R5: A status bit stays set until the host clears it, whatever later readings arrive.
- R6: Writing a mask to 0x13 clears the status bits where the mask bits [3:0] are one. If a set and a clear reach the same bit in the same cycle, the set wins. Address 0x13 always reads zero.
- R7: Bit0 of the configuration register at 0x1A is the disable bit, where 1 means disabled. Bits [7:1] read as zero.
- R8: While the block is disabled, strobes have no effect. The temperature pair keeps its value and no status bit sets.
- R9: Writes to 0x31, 0x32, 0x33 and to unmapped addresses change nothing. Unmapped addresses read zero.
- R10: After reset the temperature, all limits, the status register and the disable bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Reading strobe, one cycle per reading |
| smp_temp | input | TEMP_W | Signed reading, 0.25 °C per LSB |
| host_addr | input | 8 | Register byte address |
| host_wr | input | 1 | Write strobe for host_wdata at host_addr |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data byte for host_addr (combinational) |

## Verification
The checker tests four things on every cycle:
- A status bit falls only after a clear write whose mask covers that bit.
- A status bit rises only after a strobe that arrived while the block was enabled.
- While the block is disabled or no strobe arrives, the temperature stays frozen.
- The clear register, the configuration register and the reserved bits of the temperature pair read back with their fixed zeros.

Some behaviour needs the bench's scenarios instead:
- whether a comparison is strict at a limit exactly equal to the reading
- whether signed extremes compare correctly
- whether a byte write reaches the right limit pair
- which side wins when a set and a clear land together

// File: rtl/thermal_limit_pkg.sv
package thermal_limit_pkg;

   localparam int          NUM_LIMITS  = 4;
   localparam int          FIELD_LSB   = 2;
   localparam int          PAIR_W      = 16;
   localparam logic [7:0]  ADR_CLEAR   = 8'h13;
   localparam logic [7:0]  ADR_CONFIG  = 8'h1A;
   localparam logic [7:0]  ADR_LIM0    = 8'h1C;
   localparam logic [7:0]  ADR_TEMP    = 8'h31;
   localparam logic [7:0]  ADR_STATUS  = 8'h33;

   // Index of each limit doubles as its status bit position.
   typedef enum int {
      LIM_HIGH  = 0,
      LIM_LOW   = 1,
      LIM_CRIT  = 2,
      LIM_LCRIT = 3
   } limit_idx_e;

   function automatic logic [7:0] limit_base(input int idx);
      return ADR_LIM0 + 8'(2 * idx);
   endfunction

   // Even indices guard an upper bound, odd indices a lower bound.
   function automatic logic is_upper(input int idx);
      return (idx % 2) == 0;
   endfunction

endpackage

// File: rtl/thermal_field_reg.sv
module thermal_field_reg
   import thermal_limit_pkg::*;
#(
   parameter int          TEMP_W  = 11,
   parameter logic [TEMP_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [7:0]        wdata,
   output logic [TEMP_W-1:0] q
);

   logic [PAIR_W-1:0] cur_pair;
   logic [PAIR_W-1:0] nxt_pair;

   assign cur_pair = PAIR_W'(q) << FIELD_LSB;

   always_comb begin
      nxt_pair = cur_pair;
      if (wr_lo) nxt_pair[7:0]  = wdata;
      if (wr_hi) nxt_pair[15:8] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q <= RST_VAL;
      else if (wr_lo || wr_hi)  q <= nxt_pair[FIELD_LSB +: TEMP_W];
   end

endmodule

// File: rtl/thermal_limit_cmp.sv
module thermal_limit_cmp
   import thermal_limit_pkg::*;
#(
   parameter int TEMP_W = 11
) (
   input  logic [TEMP_W-1:0]                  sample,
   input  logic [NUM_LIMITS-1:0][TEMP_W-1:0]  limits,
   output logic [NUM_LIMITS-1:0]              hit
);

   for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_cmp
      if (is_upper(g)) begin : g_above
         assign hit[g] = $signed(sample) > $signed(limits[g]);
      end else begin : g_below
         assign hit[g] = $signed(sample) < $signed(limits[g]);
      end
   end

endmodule

// File: rtl/thermal_alarm_status.sv
module thermal_alarm_status
   import thermal_limit_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LIMITS-1:0] set_i,
   input  logic [NUM_LIMITS-1:0] clr_i,
   output logic [NUM_LIMITS-1:0] status_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_i) | set_i;
   end

endmodule

// File: rtl/thermal_limit_monitor.sv
module thermal_limit_monitor
   import thermal_limit_pkg::*;
#(
   parameter int TEMP_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [TEMP_W-1:0] smp_temp,
   input  logic [7:0]        host_addr,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata
);

   if (TEMP_W < 7 || TEMP_W > PAIR_W - FIELD_LSB) begin : g_bad_width
      $error("TEMP_W must lie between 7 and 14");
   end

   logic [NUM_LIMITS-1:0][TEMP_W-1:0] lim_val;
   logic [PAIR_W-1:0]                 lim_pair [NUM_LIMITS];
   logic [NUM_LIMITS-1:0]             hit;
   logic [NUM_LIMITS-1:0]             set_vec;
   logic [NUM_LIMITS-1:0]             clr_vec;
   logic [NUM_LIMITS-1:0]             status_q;
   logic [TEMP_W-1:0]                 temp_q;
   logic [PAIR_W-1:0]                 temp_pair;
   logic                              disable_q;
   logic                              accept;

   for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_limit
      logic wlo;
      logic whi;
      assign wlo = host_wr && (host_addr == limit_base(g));
      assign whi = host_wr && (host_addr == limit_base(g) + 8'd1);

      thermal_field_reg #(.TEMP_W(TEMP_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (wlo),
         .wr_hi (whi),
         .wdata (host_wdata),
         .q     (lim_val[g])
      );

      assign lim_pair[g] = PAIR_W'(lim_val[g]) << FIELD_LSB;
   end

   thermal_limit_cmp #(.TEMP_W(TEMP_W)) u_cmp (
      .sample (smp_temp),
      .limits (lim_val),
      .hit    (hit)
   );

   assign accept  = smp_valid && !disable_q;
   assign set_vec = accept ? hit : '0;
   assign clr_vec = (host_wr && host_addr == ADR_CLEAR) ? host_wdata[NUM_LIMITS-1:0] : '0;

   thermal_alarm_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec),
      .clr_i    (clr_vec),
      .status_q (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      temp_q <= '0;
      else if (accept) temp_q <= smp_temp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 disable_q <= 1'b0;
      else if (host_wr && host_addr == ADR_CONFIG) disable_q <= host_wdata[0];
   end

   assign temp_pair = PAIR_W'(temp_q) << FIELD_LSB;

   always_comb begin
      host_rdata = '0;
      for (int i = 0; i < NUM_LIMITS; i++) begin
         if (host_addr == limit_base(i))         host_rdata = lim_pair[i][7:0];
         if (host_addr == limit_base(i) + 8'd1)  host_rdata = lim_pair[i][15:8];
      end
      if (host_addr == ADR_TEMP)         host_rdata = temp_pair[7:0];
      if (host_addr == ADR_TEMP + 8'd1)  host_rdata = temp_pair[15:8];
      if (host_addr == ADR_STATUS)       host_rdata = 8'(status_q);
      if (host_addr == ADR_CONFIG)       host_rdata = {7'd0, disable_q};
   end

endmodule

// File: rtl/thermal_limit_checker.sv
module thermal_limit_checker
   import thermal_limit_pkg::*;
#(
   parameter int TEMP_W = 11
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  smp_valid,
   input logic [TEMP_W-1:0]     smp_temp,
   input logic [7:0]            host_addr,
   input logic                  host_wr,
   input logic [7:0]            host_wdata,
   input logic [7:0]            host_rdata,
   input logic [NUM_LIMITS-1:0] status_q,
   input logic [TEMP_W-1:0]     temp_q,
   input logic                  disable_q
);

   localparam int HI_SHIFT = TEMP_W + FIELD_LSB - 8;

   for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_bit
      // R5: a status bit drops only after a clear write that covers it
      a_r5_sticky_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(status_q[g]) |-> $past(host_wr && host_addr == ADR_CLEAR && host_wdata[g]));

      // R8: a status bit rises only after an accepted strobe
      a_r8_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status_q[g]) |-> $past(smp_valid && !disable_q));
   end

   a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !disable_q) |=> (temp_q == $past(smp_temp)));

   a_r8_temp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid || disable_q) |=> $stable(temp_q));

   a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADR_CLEAR) |-> (host_rdata == 8'd0));

   a_r7_config_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADR_CONFIG) |-> (host_rdata[7:1] == 7'd0));

   a_r3_temp_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADR_TEMP) |-> (host_rdata[1:0] == 2'd0));

   a_r3_temp_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADR_TEMP + 8'd1) |-> ((host_rdata >> HI_SHIFT) == 8'd0));

endmodule

bind thermal_limit_monitor thermal_limit_checker #(.TEMP_W(TEMP_W)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .smp_temp   (smp_temp),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .status_q   (status_q),
   .temp_q     (temp_q),
   .disable_q  (disable_q)
);

// File: tb/test_thermal_limit_monitor.sv
`timescale 1ns/1ps
module test_thermal_limit_monitor;

   localparam int TW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [TW-1:0] smp_temp = '0;
   logic [7:0]    host_addr = '0;
   logic          host_wr = 1'b0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   logic [TW-1:0] m_lim [4];
   logic [TW-1:0] m_temp;
   logic [3:0]    m_st;
   logic          m_dis;

   always #2 clk = ~clk;

   thermal_limit_monitor #(.TEMP_W(TW)) i_thermal_limit_monitor (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   function automatic logic [15:0] pk(input logic [TW-1:0] v);
      return 16'(v) << 2;
   endfunction

   function automatic logic [3:0] m_hits(input logic [TW-1:0] v);
      logic [3:0] h;
      h[0] = $signed(v) > $signed(m_lim[0]);
      h[1] = $signed(v) < $signed(m_lim[1]);
      h[2] = $signed(v) > $signed(m_lim[2]);
      h[3] = $signed(v) < $signed(m_lim[3]);
      return h;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      logic [15:0] p;
      for (int i = 0; i < 4; i++) begin
         p = pk(m_lim[i]);
         if (a == 8'h1C + 8'(2*i)) return p[7:0];
         if (a == 8'h1D + 8'(2*i)) return p[15:8];
      end
      p = pk(m_temp);
      if (a == 8'h31) return p[7:0];
      if (a == 8'h32) return p[15:8];
      if (a == 8'h33) return {4'd0, m_st};
      if (a == 8'h1A) return {7'd0, m_dis};
      return 8'd0;
   endfunction

   task automatic m_write(input logic [7:0] a, input logic [7:0] d);
      logic [15:0] p;
      for (int i = 0; i < 4; i++) begin
         p = pk(m_lim[i]);
         if (a == 8'h1C + 8'(2*i)) begin p[7:0] = d;  m_lim[i] = p[12:2]; end
         if (a == 8'h1D + 8'(2*i)) begin p[15:8] = d; m_lim[i] = p[12:2]; end
      end
      if (a == 8'h13) m_st = m_st & ~d[3:0];
      if (a == 8'h1A) m_dis = d[0];
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      host_wr = 1'b0;
      m_write(a, d);
   endtask

   task automatic strobe(input logic [TW-1:0] v);
      smp_valid = 1'b1; smp_temp = v;
      @(posedge clk); @(negedge clk);
      smp_valid = 1'b0;
      if (!m_dis) begin
         m_temp = v;
         m_st = m_st | m_hits(v);
      end
   endtask

   task automatic chk(input logic [7:0] a, input string tag);
      logic [7:0] e;
      host_addr = a;
      #0.5;
      e = exp_rd(a);
      n_cmp++;
      if (host_rdata !== e) begin
         n_bad++;
         $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h", tag, a, host_rdata, e);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int a = 8'h10; a < 8'h38; a++) chk(8'(a), tag);
   endtask

   task automatic set_lim(input int i, input logic [TW-1:0] v);
      logic [15:0] p;
      p = pk(v);
      wr(8'h1C + 8'(2*i), p[7:0]);
      wr(8'h1D + 8'(2*i), p[15:8]);
   endtask

   initial begin
      #(4.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 4; i++) m_lim[i] = '0;
      m_temp = '0; m_st = '0; m_dis = 1'b0;
      r = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: everything zero after reset
      chk_all("R10");

      // R2: program limits 85.00, -10.00, 100.00, -40.00 degC
      set_lim(0, 11'sd340);
      set_lim(1, -11'sd40);
      set_lim(2, 11'sd400);
      set_lim(3, -11'sd160);
      chk_all("R2");

      // R3: reserved bits discarded on write, read as zero
      wr(8'h1C, 8'hFF); wr(8'h1D, 8'hFF);
      chk(8'h1C, "R3"); chk(8'h1D, "R3");
      set_lim(0, 11'sd340);

      // R4: equal to limit does not trip; one LSB above does
      strobe(11'sd340);  chk(8'h33, "R4"); chk(8'h31, "R1"); chk(8'h32, "R1");
      strobe(11'sd341);  chk(8'h33, "R4");
      strobe(-11'sd40);  chk(8'h33, "R4");
      strobe(-11'sd41);  chk(8'h33, "R4");

      // R5: bits stay set after return to range
      strobe(11'sd100);  chk(8'h33, "R5"); chk(8'h31, "R1");

      // R6: masked clear, clear register reads zero
      wr(8'h13, 8'h01);  chk(8'h33, "R6"); chk(8'h13, "R6");
      wr(8'h13, 8'hFE);  chk(8'h33, "R6");

      // R6: set wins over simultaneous clear
      strobe(-11'sd41);
      smp_valid = 1'b1; smp_temp = 11'sd500;
      host_addr = 8'h13; host_wdata = 8'h0F; host_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      smp_valid = 1'b0; host_wr = 1'b0;
      m_st = (m_st & ~4'hF) | m_hits(11'sd500);
      m_temp = 11'sd500;
      chk(8'h33, "R6");

      // R7/R8: disable freezes temperature and status
      wr(8'h13, 8'h0F);
      wr(8'h1A, 8'hFF); chk(8'h1A, "R7");
      strobe(-11'sd300); chk(8'h31, "R8"); chk(8'h32, "R8"); chk(8'h33, "R8");
      wr(8'h1A, 8'h00); chk(8'h1A, "R7");

      // R9: writes to read-only and unmapped addresses ignored
      wr(8'h31, 8'hAA); wr(8'h32, 8'hAA); wr(8'h33, 8'hFF); wr(8'h05, 8'h55); wr(8'h24, 8'h77);
      chk_all("R9");

      // R1: signed extremes
      strobe(11'h400); chk(8'h31, "R1"); chk(8'h32, "R1"); chk(8'h33, "R4");
      strobe(11'h3FF); chk(8'h31, "R1"); chk(8'h32, "R1"); chk(8'h33, "R4");

      // Constrained random mix
      for (int n = 0; n < 600; n++) begin
         r = $urandom % 100;
         if (r < 50) begin
            strobe(11'(($urandom % 1200) - 600));
         end else if (r < 70) begin
            wr(8'h1C + 8'($urandom % 8), 8'($urandom));
         end else if (r < 85) begin
            wr(8'h13, 8'($urandom));
         end else if (r < 93) begin
            wr(8'h1A, 8'(($urandom % 4 == 0) ? 1 : 0));
         end else begin
            wr(8'h31 + 8'($urandom % 3), 8'($urandom));
         end
         if (n % 25 == 24) chk_all("R4");
      end
      chk_all("R5");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule